// File: doc/BRIEF.md
# RMII Dual-Speed Di-bit Adapter

This block sits between a nibble-wide MAC-side data stream and the two-bit reduced media-independent data path, in both directions. On the transmit side it collects di-bits arriving with a transmit-enable qualifier and packs them into nibbles, which it emits with a one-cycle valid pulse. On the receive side it accepts nibbles from an internal source through a ready/valid pair and plays each one out as two di-bits, with a carrier/data-valid flag that covers the frame.

The whole block runs from one 50 MHz reference clock in both speeds. At 100 Mbps one di-bit moves per clock. At 10 Mbps the clock is not slowed: every receive di-bit is held for ten clocks, and on transmit one di-bit is captured per ten-clock window at a fixed offset from the rise of transmit enable. The speed is picked by a static input that is latched only between frames. The carrier flag is never derived from transmit enable.

Top module: `rmii_dibit_adapter`

## Requirements
- R1: On transmit, the first captured di-bit of a pair lands in nibble bits [1:0] and the second in bits [3:2]; the packed nibble appears on `tx_nib` with a single-cycle `tx_nib_vld` pulse in the cycle after the second di-bit is captured. At 100 Mbps (`speed_10`=0) one di-bit is captured on every clock while `tx_en` is 1.
- R2: At 10 Mbps (`speed_10`=1), exactly one di-bit is captured per ten-clock window, at offset 4 of the window, where offset 0 is the first clock with `tx_en` at 1; windows follow back to back while `tx_en` stays 1, and a new rise of `tx_en` restarts the count.
- R3: When `tx_en` falls after an odd number of captured di-bits, the lone di-bit is dropped and no nibble is produced; the next frame starts packing from bits [1:0].
- R4: At 100 Mbps each accepted nibble is shown on `rxd` for two clocks, bits [1:0] first and bits [3:2] second, starting the clock after `src_vld` and `src_rdy` are both 1; `src_rdy` is 1 in the last di-bit clock so back-to-back nibbles leave no gap, and `crs_dv` is 1 from the first di-bit clock to the last.
- R5: At 10 Mbps each receive di-bit is held on `rxd` for ten consecutive clocks, and `crs_dv` stays 1 across the whole final ten-clock window of the frame.
- R6: With no nibble in flight, `crs_dv` is 0 and `rxd` is 00; activity on `tx_en` and `txd` never raises `crs_dv`.
- R7: Each direction latches `speed_10` only while idle (transmit: `tx_en` at 0; receive: no nibble in flight, including the clock that accepts the first nibble); a change during a frame takes effect from the next frame.
- R8: `rst` is synchronous and active high; it clears the di-bit phase, the window counters and `crs_dv`, so after it `crs_dv`=0, `tx_nib_vld`=0, `src_rdy`=1 and a partly sent frame is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_10 | input | 1 | 1 selects 10 Mbps, 0 selects 100 Mbps; latched between frames |
| tx_en | input | 1 | Transmit di-bit qualifier |
| txd | input | 2 | Transmit di-bit |
| tx_nib | output | 4 | Packed transmit nibble |
| tx_nib_vld | output | 1 | One-cycle pulse marking a new `tx_nib` |
| src_vld | input | 1 | Receive nibble offered |
| src_nib | input | 4 | Receive nibble |
| src_rdy | output | 1 | Adapter takes `src_nib` this clock when `src_vld` is 1 |
| rxd | output | 2 | Receive di-bit |
| crs_dv | output | 1 | Carrier and receive data valid |

## Verification
A packed transmit nibble is due one clock after the capture of its second di-bit, so its pulse comes `hold*(2i+1)+offset+1` clocks after the first driven di-bit (hold 1 or 10, offset 0 or 4); the bench stamps every pulse with a cycle number and compares it against that figure as well as the value. Receive di-bits start one clock after the accepting edge and then step every one or ten clocks, so the bench records every `crs_dv` clock and checks the onset cycle, the run length, that the run has no gap, and each di-bit against its position. Inputs change and outputs are read at the falling edge, so each sample sees only registers updated at the preceding rising edge.

// File: rtl/rmii_dibit_pkg.sv
`timescale 1ns/1ps
package rmii_dibit_pkg;

    localparam int NIB_W = 4;
    localparam int DIB_W = 2;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [DIB_W-1:0] dib_t;

    typedef enum logic {
        SPD_FAST = 1'b0,
        SPD_SLOW = 1'b1
    } speed_e;

    // receive playout state: nibble in flight and which half is on the wire
    typedef struct packed {
        logic act;
        logic half;
        nib_t nib;
    } rx_state_t;

    function automatic dib_t dib_pick(nib_t n, logic upper);
        return upper ? n[3:2] : n[1:0];
    endfunction

    function automatic nib_t nib_join(dib_t hi, dib_t lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/rmii_win_cnt.sv
`timescale 1ns/1ps
module rmii_win_cnt #(
    parameter int REP = 10,
    localparam int CW = (REP > 1) ? $clog2(REP) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          run,
    output logic [CW-1:0] cnt
);

    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == CW'(REP - 1));
    assign cnt    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= at_end ? '0 : cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/rmii_tx_pack.sv
`timescale 1ns/1ps
module rmii_tx_pack
    import rmii_dibit_pkg::*;
#(
    parameter int REP       = 10,
    parameter int SAMPLE_PH = 4,
    localparam int CW = (REP > 1) ? $clog2(REP) : 1
) (
    input  logic   clk,
    input  logic   rst,
    input  speed_e speed,
    input  logic   tx_en,
    input  dib_t   txd,
    output nib_t   nib_o,
    output logic   vld_o
);

    speed_e        spd_q;
    logic          half_q;
    dib_t          lo_q;
    nib_t          nib_q;
    logic          vld_q;
    logic [CW-1:0] cnt;
    logic          strobe;

    // counter sits at 0 whenever tx_en is low, so offset 0 is the rise cycle
    rmii_win_cnt #(.REP(REP)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (!tx_en),
        .run (tx_en),
        .cnt (cnt)
    );

    assign strobe = tx_en && ((spd_q == SPD_FAST) || (cnt == CW'(SAMPLE_PH)));

    always_ff @(posedge clk) begin
        if (rst) begin
            spd_q  <= SPD_FAST;
            half_q <= 1'b0;
            lo_q   <= '0;
            nib_q  <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (!tx_en) begin
                spd_q  <= speed;
                half_q <= 1'b0;
            end else if (strobe) begin
                if (!half_q) begin
                    lo_q   <= txd;
                    half_q <= 1'b1;
                end else begin
                    nib_q  <= nib_join(txd, lo_q);
                    vld_q  <= 1'b1;
                    half_q <= 1'b0;
                end
            end
        end
    end

    assign nib_o = nib_q;
    assign vld_o = vld_q;

endmodule

// File: rtl/rmii_rx_split.sv
`timescale 1ns/1ps
module rmii_rx_split
    import rmii_dibit_pkg::*;
#(
    parameter int REP = 10,
    localparam int CW = (REP > 1) ? $clog2(REP) : 1
) (
    input  logic   clk,
    input  logic   rst,
    input  speed_e speed,
    input  logic   src_vld,
    input  nib_t   src_nib,
    output logic   src_rdy,
    output dib_t   rxd,
    output logic   crs_dv
);

    rx_state_t     st_q;
    speed_e        spd_q;
    logic [CW-1:0] cnt;
    logic          slot_end;
    logic          last_slot;
    logic          take;

    rmii_win_cnt #(.REP(REP)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (!st_q.act),
        .run (st_q.act && (spd_q == SPD_SLOW)),
        .cnt (cnt)
    );

    assign slot_end  = st_q.act && ((spd_q == SPD_FAST) || (cnt == CW'(REP - 1)));
    assign last_slot = slot_end && st_q.half;
    assign src_rdy   = !st_q.act || last_slot;
    assign take      = src_vld && src_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            spd_q <= SPD_FAST;
        end else begin
            if (!st_q.act) begin
                spd_q <= speed;
            end
            if (take) begin
                st_q <= '{act: 1'b1, half: 1'b0, nib: src_nib};
            end else if (last_slot) begin
                st_q <= '0;
            end else if (slot_end) begin
                st_q.half <= 1'b1;
            end
        end
    end

    assign rxd    = st_q.act ? dib_pick(st_q.nib, st_q.half) : '0;
    assign crs_dv = st_q.act;

endmodule

// File: rtl/rmii_dibit_adapter.sv
`timescale 1ns/1ps
module rmii_dibit_adapter
    import rmii_dibit_pkg::*;
#(
    parameter int REP       = 10,
    parameter int SAMPLE_PH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       speed_10,
    input  logic       tx_en,
    input  logic [1:0] txd,
    output logic [3:0] tx_nib,
    output logic       tx_nib_vld,
    input  logic       src_vld,
    input  logic [3:0] src_nib,
    output logic       src_rdy,
    output logic [1:0] rxd,
    output logic       crs_dv
);

    speed_e spd_sel;
    assign spd_sel = speed_e'(speed_10);

    rmii_tx_pack #(.REP(REP), .SAMPLE_PH(SAMPLE_PH)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .speed (spd_sel),
        .tx_en (tx_en),
        .txd   (txd),
        .nib_o (tx_nib),
        .vld_o (tx_nib_vld)
    );

    // carrier comes from the receive path only; tx_en never feeds it
    rmii_rx_split #(.REP(REP)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .speed   (spd_sel),
        .src_vld (src_vld),
        .src_nib (src_nib),
        .src_rdy (src_rdy),
        .rxd     (rxd),
        .crs_dv  (crs_dv)
    );

endmodule

// File: rtl/rmii_dibit_chk.sv
`timescale 1ns/1ps
module rmii_dibit_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic tx_nib_vld,
    input logic src_vld,
    input logic src_rdy,
    input logic crs_dv
);

    assert_tx_pulse_single_R1: assert property (@(posedge clk) disable iff (rst)
        tx_nib_vld |=> !tx_nib_vld);

    assert_tx_pulse_cause_R1: assert property (@(posedge clk) disable iff (rst)
        tx_nib_vld |-> $past(tx_en));

    assert_idle_ready_R4: assert property (@(posedge clk) disable iff (rst)
        !crs_dv |-> src_rdy);

    assert_crs_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (crs_dv && !src_rdy) |=> crs_dv);

    assert_no_loopback_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(crs_dv) |-> $past(src_vld));

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!crs_dv && !tx_nib_vld && src_rdy));

endmodule

bind rmii_dibit_adapter rmii_dibit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .tx_nib_vld (tx_nib_vld),
    .src_vld    (src_vld),
    .src_rdy    (src_rdy),
    .crs_dv     (crs_dv)
);

// File: tb/rmii_dibit_adapter_tb.sv
`timescale 1ns/1ps
module rmii_dibit_adapter_tb;

    localparam int REP = 10;
    localparam int PH  = 4;
    localparam int NV  = 5;
    // {speed_10, frame data (4 nibbles, low nibble first), expected crs_dv length}
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 16'h1234, 7'd8},
        {1'b0, 16'hA5C3, 7'd8},
        {1'b1, 16'h9E71, 7'd80},
        {1'b0, 16'hB04D, 7'd8},
        {1'b1, 16'h6F28, 7'd80}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       speed_10 = 1'b0;
    logic       tx_en = 1'b0;
    logic [1:0] txd = 2'b00;
    logic [3:0] tx_nib;
    logic       tx_nib_vld;
    logic       src_vld = 1'b0;
    logic [3:0] src_nib = 4'h0;
    logic       src_rdy;
    logic [1:0] rxd;
    logic       crs_dv;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [3:0] txq [$];
    int         txt [$];
    logic [1:0] rxq [$];
    int         rxt [$];

    always #2.5 clk = ~clk;

    rmii_dibit_adapter #(.REP(REP), .SAMPLE_PH(PH)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .speed_10   (speed_10),
        .tx_en      (tx_en),
        .txd        (txd),
        .tx_nib     (tx_nib),
        .tx_nib_vld (tx_nib_vld),
        .src_vld    (src_vld),
        .src_nib    (src_nib),
        .src_rdy    (src_rdy),
        .rxd        (rxd),
        .crs_dv     (crs_dv)
    );

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (tx_nib_vld) begin
            txq.push_back(tx_nib);
            txt.push_back(cyc);
        end
        if (crs_dv) begin
            rxq.push_back(rxd);
            rxt.push_back(cyc);
        end
    endtask

    task automatic clrq();
        txq.delete();
        txt.delete();
        rxq.delete();
        rxt.delete();
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tx_frame(logic spd, logic [15:0] data, bit garble, int flip_at, string req);
        int hold;
        int t0;
        logic [3:0] nb;
        logic [1:0] d;
        speed_10 = spd;
        repeat (3) tick();
        clrq();
        t0 = cyc;
        hold = spd ? REP : 1;
        for (int k = 0; k < 8; k++) begin
            nb = data[4*(k/2) +: 4];
            d  = (k % 2 == 1) ? nb[3:2] : nb[1:0];
            for (int c = 0; c < hold; c++) begin
                if (k == flip_at && c == 0) speed_10 = ~spd;
                tx_en = 1'b1;
                txd   = (garble && c != PH) ? ~d : d;
                tick();
            end
        end
        tx_en = 1'b0;
        txd   = 2'b00;
        repeat (3) tick();
        chk(req, "tx nibble count", txq.size(), 4);
        for (int i = 0; i < 4; i++) begin
            if (i < txq.size()) begin
                chk(req, "tx nibble value", int'(txq[i]), int'(data[4*i +: 4]));
                chk(req, "tx nibble cycle", txt[i] - t0,
                    hold * (2*i + 1) + (spd ? PH : 0) + 1);
            end
        end
        chk("R6", "crs_dv raised by transmit", rxq.size(), 0);
    endtask

    task automatic rx_frame(logic spd, logic [15:0] data, int exp_len, int flip_at, string req);
        int hold;
        int t0;
        int idx;
        int bad;
        speed_10 = spd;
        src_vld  = 1'b0;
        repeat (3) tick();
        clrq();
        t0   = cyc;
        hold = spd ? REP : 1;
        idx  = 0;
        for (int j = 0; j < 8*hold + 6; j++) begin
            if (j == flip_at) speed_10 = ~spd;
            if (idx < 4) begin
                src_vld = 1'b1;
                src_nib = data[4*idx +: 4];
                if (src_rdy) idx++;
            end else begin
                src_vld = 1'b0;
            end
            tick();
        end
        src_vld = 1'b0;
        repeat (2) tick();
        chk(req, "crs_dv length", rxq.size(), exp_len);
        if (rxq.size() > 0) begin
            chk(req, "crs_dv onset cycle", rxt[0] - t0, 1);
            chk(req, "crs_dv contiguous", rxt[rxq.size()-1] - rxt[0] + 1, rxq.size());
        end
        bad = 0;
        for (int p = 0; p < rxq.size(); p++) begin
            if (rxq[p] != data[4*(p/(2*hold)) + 2*((p/hold)%2) +: 2]) bad++;
        end
        chk(req, "rxd di-bit mismatches", bad, 0);
        chk("R6", "rxd idle value", int'(rxd), 0);
        chk("R6", "crs_dv idle", int'(crs_dv), 0);
    endtask

    initial begin
        #750000;
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: state held in and after reset
        repeat (3) tick();
        chk("R8", "crs_dv in reset", int'(crs_dv), 0);
        rst = 1'b0;
        tick();
        chk("R8", "crs_dv after reset", int'(crs_dv), 0);
        chk("R8", "tx_nib_vld after reset", int'(tx_nib_vld), 0);
        chk("R8", "src_rdy after reset", int'(src_rdy), 1);
        chk("R6", "rxd after reset", int'(rxd), 0);

        // table walk: R1/R2 on transmit, R4/R5 on receive
        for (int v = 0; v < NV; v++) begin
            tx_frame(VEC[v][23], VEC[v][22:7], 1'b0, -1, VEC[v][23] ? "R2" : "R1");
            rx_frame(VEC[v][23], VEC[v][22:7], int'(VEC[v][6:0]), -1, VEC[v][23] ? "R5" : "R4");
        end

        // R2: only offset 4 of each window carries the true di-bit
        tx_frame(1'b1, 16'hC39A, 1'b1, -1, "R2");

        // R3: a lone di-bit before tx_en drops yields nothing and leaves no phase behind
        speed_10 = 1'b0;
        repeat (3) tick();
        clrq();
        tx_en = 1'b1;
        txd   = 2'b11;
        tick();
        tx_en = 1'b0;
        txd   = 2'b00;
        repeat (3) tick();
        chk("R3", "nibbles from lone di-bit", txq.size(), 0);
        tx_frame(1'b0, 16'h2C84, 1'b0, -1, "R3");

        // R7: speed flips mid-frame are ignored until the frame ends
        tx_frame(1'b0, 16'h5E17, 1'b0, 2, "R7");
        rx_frame(1'b0, 16'h7D3B, 8, 3, "R7");
        speed_10 = 1'b1;
        rx_frame(1'b1, 16'h48E6, 80, 15, "R7");

        // R8: reset in the middle of a slow receive frame
        speed_10 = 1'b1;
        repeat (3) tick();
        src_vld = 1'b1;
        src_nib = 4'hF;
        tick();
        src_vld = 1'b0;
        repeat (14) tick();
        chk("R8", "crs_dv before mid-frame reset", int'(crs_dv), 1);
        rst = 1'b1;
        tick();
        chk("R8", "crs_dv after mid-frame reset", int'(crs_dv), 0);
        chk("R8", "src_rdy after mid-frame reset", int'(src_rdy), 1);
        rst = 1'b0;
        rx_frame(1'b0, 16'h91AF, 8, -1, "R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule